// File: doc/BRIEF.md
# Macroblock Output Port Sequencer

This block drives one macroblock of coded video onto a byte-wide output bus. Each item on the bus carries a 4-bit mode tag and a strobe. The receiver latches each item on the rising edge of the strobe. A start pulse captures the macroblock header fields. The sequencer then issues a short wait, the control-decision byte and, unless the macroblock is a dummy, the group number, macroblock number, coded block pattern, quantiser and both motion-vector components. Each of these items lasts two cycles.

When the coded block pattern has any bit set, a 32-cycle wait follows. Each coded sub-block is then sent as its index, followed by run/level pairs taken from a valid/ready coefficient source. Each sub-block is padded so that it takes at least 335 cycles. After the last item the bus shows the wait code until the next start pulse.

Top module: `mb_out_seq`

## Requirements
- R1: The mode tag uses these codes: group 0, macroblock number 1, control 2, quantiser 3, horizontal vector 4, vertical vector 5, coded block pattern 6, sub-block index 7, zero-run 8, coefficient level 9, wait 15. Codes 10 to 14 never appear.
- R2: The strobe is low in the first cycle of every non-wait item and high in the rest of its cycles. It falls on the edge that changes the mode, and it stays low for the whole of every wait.
- R3: The control byte has the fixed-macroblock flag in bit 0, inter (1) or intra (0) in bit 1, filtered in bit 2, motion compensated in bit 3, fast update in bit 5 and skip frame in bit 6. Bits 4 and 7 are 0.
- R4: The header inputs are captured in the cycle of the start pulse. The start is followed by 2 wait cycles and then a 2-cycle control item. For a dummy macroblock, nothing else follows.
- R5: For a non-dummy macroblock, the control item is followed by group, macroblock number, coded block pattern (6 bits in bits 5:0, upper bits 0), quantiser, horizontal vector and vertical vector. Each lasts 2 cycles and shows the captured field.
- R6: Once a sequence ends (dummy, zero coded block pattern, or last coded sub-block done), the bus shows mode 15, data 0 and strobe low until the next accepted start. A zero pattern ends the sequence directly after the vertical vector, with no 32-cycle wait.
- R7: A non-zero pattern adds a 32-cycle wait. Then each sub-block whose pattern bit is set is sent in ascending index order 0 to 5, starting with a 15-cycle item of mode 7 whose data is the index.
- R8: A coefficient is taken on a clock edge where coef_ready and coef_valid are both high. Each one is sent as run (2 cycles), level (2 cycles) and a 1-cycle wait. coef_last marks the final coefficient of a sub-block.
- R9: After the final coefficient's 1-cycle wait, the wait code is held until 335 cycles have passed since the sub-block's index item began. There is no padding when that count has already been reached, for example with 64 coefficients.
- R10: If no coefficient is valid when one is due, the bus shows the wait code with the strobe low until one arrives. The run item then starts on the next cycle.
- R11: A start pulse that arrives while a macroblock is in progress is ignored.
- R12: Synchronous reset puts the bus at mode 15, data 0, strobe low and coef_ready low, from any point in a sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin one macroblock (accepted when idle) |
| hdr_dummy | input | 1 | Dummy macroblock: control item only |
| hdr_fixed | input | 1 | Fixed-macroblock decision |
| hdr_inter | input | 1 | Inter (1) / intra (0) |
| hdr_filtered | input | 1 | Loop filter applied |
| hdr_mcomp | input | 1 | Motion compensation applied |
| hdr_fast_upd | input | 1 | Frame coded in fast-update mode |
| hdr_skip | input | 1 | Frame skipped |
| hdr_group | input | 8 | Group number |
| hdr_mbnum | input | 8 | Macroblock number |
| hdr_cbp | input | 6 | Coded block pattern, bit i = sub-block i |
| hdr_quant | input | 8 | Quantiser value |
| hdr_mv_x | input | 8 | Horizontal motion vector |
| hdr_mv_y | input | 8 | Vertical motion vector |
| coef_valid | input | 1 | Coefficient pair available |
| coef_run | input | 8 | Zero-run count |
| coef_level | input | 8 | Coefficient level |
| coef_last | input | 1 | Final coefficient of the sub-block |
| coef_ready | output | 1 | Sequencer takes a coefficient this cycle if valid |
| bus_data | output | 8 | Output data byte |
| bus_mode | output | 4 | Mode tag of bus_data |
| bus_strobe | output | 1 | Data strobe |

## Verification
The bench compares every cycle of the bus against a trace that it builds from the header fields and the coefficient lists. It covers a dummy macroblock, an empty pattern, sparse and full patterns, and a sub-block of 64 coefficients. A design with an off-by-one in the 335-cycle budget would shift every later sub-block. A design that padded a full sub-block, or one that stalled, would add cycles where none belong. The bench also withholds a coefficient well past the budget. This exposes a pad counter that wraps or that ignores stall time, and a run item that starts before the handshake. It pulses start in mid-sequence, changes the header inputs after capture, and asserts reset mid-macroblock. A design that restarted, that read live header inputs, or that left the strobe or coef_ready high would be caught.

// File: rtl/mbseq_pkg.sv
package mbseq_pkg;

    localparam int BUS_W      = 8;
    localparam int NUM_SB     = 6;
    localparam int SB_IW      = $clog2(NUM_SB);
    localparam int HDR_EVENTS = 7;

    typedef enum logic [3:0] {
        MD_GROUP  = 4'd0,
        MD_MBNUM  = 4'd1,
        MD_CTRL   = 4'd2,
        MD_QUANT  = 4'd3,
        MD_MVX    = 4'd4,
        MD_MVY    = 4'd5,
        MD_CBP    = 4'd6,
        MD_SUBBLK = 4'd7,
        MD_RUN    = 4'd8,
        MD_LEVEL  = 4'd9,
        MD_WAIT   = 4'd15
    } bus_mode_e;

    typedef enum logic [3:0] {
        ST_IDLE, ST_PRE, ST_HDR, ST_GAP32, ST_SBNUM,
        ST_STALL, ST_RUN, ST_LEVEL, ST_GAP, ST_PAD
    } seq_state_e;

    typedef struct packed {
        logic skip;
        logic fast_upd;
        logic mcomp;
        logic filtered;
        logic inter;
        logic fixed;
    } ctl_flags_t;

    typedef struct packed {
        logic              dummy;
        ctl_flags_t        ctl;
        logic [BUS_W-1:0]  group;
        logic [BUS_W-1:0]  mbnum;
        logic [NUM_SB-1:0] cbp;
        logic [BUS_W-1:0]  quant;
        logic [BUS_W-1:0]  mv_x;
        logic [BUS_W-1:0]  mv_y;
    } mb_hdr_t;

    // control byte: bits 4 and 7 stay zero
    function automatic logic [BUS_W-1:0] ctrl_byte(ctl_flags_t f);
        return {1'b0, f.skip, f.fast_upd, 1'b0, f.mcomp, f.filtered, f.inter, f.fixed};
    endfunction

    // fixed header order: this order is observable on the bus
    function automatic bus_mode_e hdr_mode(logic [2:0] i);
        case (i)
            3'd0:    return MD_CTRL;
            3'd1:    return MD_GROUP;
            3'd2:    return MD_MBNUM;
            3'd3:    return MD_CBP;
            3'd4:    return MD_QUANT;
            3'd5:    return MD_MVX;
            default: return MD_MVY;
        endcase
    endfunction

    function automatic logic [BUS_W-1:0] hdr_byte(mb_hdr_t h, logic [2:0] i);
        case (i)
            3'd0:    return ctrl_byte(h.ctl);
            3'd1:    return h.group;
            3'd2:    return h.mbnum;
            3'd3:    return BUS_W'(h.cbp);
            3'd4:    return h.quant;
            3'd5:    return h.mv_x;
            default: return h.mv_y;
        endcase
    endfunction

endpackage

// File: rtl/mbseq_sbscan.sv
module mbseq_sbscan
    import mbseq_pkg::*;
(
    input  logic [NUM_SB-1:0] mask,
    input  logic [SB_IW:0]    from,
    output logic              found,
    output logic [SB_IW-1:0]  idx
);

    // lowest set bit at or above 'from'
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = NUM_SB - 1; i >= 0; i--) begin
            if (mask[i] && ((SB_IW + 1)'(i) >= from)) begin
                found = 1'b1;
                idx   = SB_IW'(i);
            end
        end
    end

endmodule

// File: rtl/mbseq_fsm.sv
module mbseq_fsm
    import mbseq_pkg::*;
#(
    parameter int PRE_WAIT   = 2,
    parameter int CBP_WAIT   = 32,
    parameter int SB_NUM_CYC = 15,
    parameter int SB_BUDGET  = 335,
    parameter int CNT_W      = 6,
    parameter int BUD_W      = 9
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              dummy,
    input  logic [NUM_SB-1:0] cbp,
    input  logic              coef_valid,
    input  logic [BUS_W-1:0]  coef_run,
    input  logic [BUS_W-1:0]  coef_level,
    input  logic              coef_last,
    input  logic              scan_found,
    input  logic [SB_IW-1:0]  scan_idx,
    output seq_state_e        st,
    output logic [CNT_W-1:0]  cnt,
    output logic [2:0]        hidx,
    output logic [SB_IW-1:0]  sb_idx,
    output logic [BUS_W-1:0]  run_q,
    output logic [BUS_W-1:0]  lvl_q,
    output logic [SB_IW:0]    scan_from,
    output logic              coef_ready,
    output logic              hdr_load
);

    seq_state_e       st_n;
    logic [2:0]       hidx_n;
    logic [SB_IW-1:0] sb_n;
    logic             new_ev, sb_start, last_q, take;
    logic [BUD_W-1:0] sb_cnt;
    logic             budget_met;

    assign budget_met = sb_cnt >= BUD_W'(SB_BUDGET - 1);
    assign hdr_load   = (st == ST_IDLE) && start;
    assign scan_from  = (st == ST_GAP32) ? '0 : {1'b0, sb_idx} + 1'b1;
    assign coef_ready = (st == ST_SBNUM && cnt == CNT_W'(SB_NUM_CYC - 1))
                      || (st == ST_GAP && !last_q) || (st == ST_STALL);
    assign take       = coef_ready && coef_valid;

    always_comb begin
        st_n     = st;
        hidx_n   = hidx;
        sb_n     = sb_idx;
        new_ev   = 1'b0;
        sb_start = 1'b0;
        case (st)
            ST_IDLE: if (start) begin
                st_n = ST_PRE; new_ev = 1'b1;
            end
            ST_PRE: if (cnt == CNT_W'(PRE_WAIT - 1)) begin
                st_n = ST_HDR; hidx_n = '0; new_ev = 1'b1;
            end
            ST_HDR: if (cnt == CNT_W'(1)) begin
                new_ev = 1'b1;
                if (hidx == 3'd0 && dummy)
                    st_n = ST_IDLE;
                else if (hidx == 3'(HDR_EVENTS - 1))
                    st_n = (cbp == '0) ? ST_IDLE : ST_GAP32;
                else
                    hidx_n = hidx + 3'd1;
            end
            ST_GAP32: if (cnt == CNT_W'(CBP_WAIT - 1)) begin
                st_n = ST_SBNUM; sb_n = scan_idx; new_ev = 1'b1; sb_start = 1'b1;
            end
            ST_SBNUM: if (cnt == CNT_W'(SB_NUM_CYC - 1)) begin
                new_ev = 1'b1;
                st_n   = coef_valid ? ST_RUN : ST_STALL;
            end
            ST_STALL: if (coef_valid) begin
                st_n = ST_RUN; new_ev = 1'b1;
            end
            ST_RUN: if (cnt == CNT_W'(1)) begin
                st_n = ST_LEVEL; new_ev = 1'b1;
            end
            ST_LEVEL: if (cnt == CNT_W'(1)) begin
                st_n = ST_GAP; new_ev = 1'b1;
            end
            ST_GAP: begin
                new_ev = 1'b1;
                if (!last_q)
                    st_n = coef_valid ? ST_RUN : ST_STALL;
                else if (!budget_met)
                    st_n = ST_PAD;
                else if (scan_found) begin
                    st_n = ST_SBNUM; sb_n = scan_idx; sb_start = 1'b1;
                end else
                    st_n = ST_IDLE;
            end
            ST_PAD: if (budget_met) begin
                new_ev = 1'b1;
                if (scan_found) begin
                    st_n = ST_SBNUM; sb_n = scan_idx; sb_start = 1'b1;
                end else
                    st_n = ST_IDLE;
            end
            default: st_n = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= ST_IDLE;
            cnt    <= '0;
            hidx   <= '0;
            sb_idx <= '0;
            sb_cnt <= '0;
            last_q <= 1'b0;
            run_q  <= '0;
            lvl_q  <= '0;
        end else begin
            st     <= st_n;
            hidx   <= hidx_n;
            sb_idx <= sb_n;
            cnt    <= new_ev ? '0 : cnt + 1'b1;
            if (sb_start)
                sb_cnt <= '0;
            else if (sb_cnt != BUD_W'(SB_BUDGET))
                sb_cnt <= sb_cnt + 1'b1;
            if (take) begin
                run_q  <= coef_run;
                lvl_q  <= coef_level;
                last_q <= coef_last;
            end
        end
    end

endmodule

// File: rtl/mbseq_outmux.sv
module mbseq_outmux
    import mbseq_pkg::*;
#(
    parameter int CNT_W = 6
) (
    input  seq_state_e       st,
    input  logic [CNT_W-1:0] cnt,
    input  logic [2:0]       hidx,
    input  logic [SB_IW-1:0] sb_idx,
    input  mb_hdr_t          hdr,
    input  logic [BUS_W-1:0] run_q,
    input  logic [BUS_W-1:0] lvl_q,
    output bus_mode_e        mode,
    output logic [BUS_W-1:0] data,
    output logic             strobe
);

    always_comb begin
        mode = MD_WAIT;
        data = '0;
        case (st)
            ST_HDR: begin
                mode = hdr_mode(hidx);
                data = hdr_byte(hdr, hidx);
            end
            ST_SBNUM: begin
                mode = MD_SUBBLK;
                data = BUS_W'(sb_idx);
            end
            ST_RUN: begin
                mode = MD_RUN;
                data = run_q;
            end
            ST_LEVEL: begin
                mode = MD_LEVEL;
                data = lvl_q;
            end
            default: ;
        endcase
        // strobe rises one cycle into each item
        strobe = (mode != MD_WAIT) && (cnt != '0);
    end

endmodule

// File: rtl/mb_out_seq.sv
module mb_out_seq
    import mbseq_pkg::*;
#(
    parameter int PRE_WAIT   = 2,
    parameter int CBP_WAIT   = 32,
    parameter int SB_NUM_CYC = 15,
    parameter int SB_BUDGET  = 335
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic       hdr_dummy,
    input  logic       hdr_fixed,
    input  logic       hdr_inter,
    input  logic       hdr_filtered,
    input  logic       hdr_mcomp,
    input  logic       hdr_fast_upd,
    input  logic       hdr_skip,
    input  logic [7:0] hdr_group,
    input  logic [7:0] hdr_mbnum,
    input  logic [5:0] hdr_cbp,
    input  logic [7:0] hdr_quant,
    input  logic [7:0] hdr_mv_x,
    input  logic [7:0] hdr_mv_y,
    input  logic       coef_valid,
    input  logic [7:0] coef_run,
    input  logic [7:0] coef_level,
    input  logic       coef_last,
    output logic       coef_ready,
    output logic [7:0] bus_data,
    output logic [3:0] bus_mode,
    output logic       bus_strobe
);

    localparam int EV_A   = (CBP_WAIT > SB_NUM_CYC) ? CBP_WAIT : SB_NUM_CYC;
    localparam int EV_MAX = (EV_A > PRE_WAIT) ? EV_A : PRE_WAIT;
    localparam int CNT_W  = $clog2(EV_MAX + 1);
    localparam int BUD_W  = $clog2(SB_BUDGET + 1);

    mb_hdr_t          hdr_in, hdr_q;
    seq_state_e       st;
    logic [CNT_W-1:0] cnt;
    logic [2:0]       hidx;
    logic [SB_IW-1:0] sb_idx, scan_idx;
    logic [SB_IW:0]   scan_from;
    logic [BUS_W-1:0] run_q, lvl_q;
    logic             scan_found, hdr_load;
    bus_mode_e        mode;

    always_comb begin
        hdr_in.dummy        = hdr_dummy;
        hdr_in.ctl.fixed    = hdr_fixed;
        hdr_in.ctl.inter    = hdr_inter;
        hdr_in.ctl.filtered = hdr_filtered;
        hdr_in.ctl.mcomp    = hdr_mcomp;
        hdr_in.ctl.fast_upd = hdr_fast_upd;
        hdr_in.ctl.skip     = hdr_skip;
        hdr_in.group        = hdr_group;
        hdr_in.mbnum        = hdr_mbnum;
        hdr_in.cbp          = hdr_cbp;
        hdr_in.quant        = hdr_quant;
        hdr_in.mv_x         = hdr_mv_x;
        hdr_in.mv_y         = hdr_mv_y;
    end

    always_ff @(posedge clk) begin
        if (rst)
            hdr_q <= '0;
        else if (hdr_load)
            hdr_q <= hdr_in;
    end

    mbseq_sbscan u_scan (
        .mask  (hdr_q.cbp),
        .from  (scan_from),
        .found (scan_found),
        .idx   (scan_idx)
    );

    mbseq_fsm #(
        .PRE_WAIT   (PRE_WAIT),
        .CBP_WAIT   (CBP_WAIT),
        .SB_NUM_CYC (SB_NUM_CYC),
        .SB_BUDGET  (SB_BUDGET),
        .CNT_W      (CNT_W),
        .BUD_W      (BUD_W)
    ) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .dummy      (hdr_q.dummy),
        .cbp        (hdr_q.cbp),
        .coef_valid (coef_valid),
        .coef_run   (coef_run),
        .coef_level (coef_level),
        .coef_last  (coef_last),
        .scan_found (scan_found),
        .scan_idx   (scan_idx),
        .st         (st),
        .cnt        (cnt),
        .hidx       (hidx),
        .sb_idx     (sb_idx),
        .run_q      (run_q),
        .lvl_q      (lvl_q),
        .scan_from  (scan_from),
        .coef_ready (coef_ready),
        .hdr_load   (hdr_load)
    );

    mbseq_outmux #(
        .CNT_W (CNT_W)
    ) u_out (
        .st     (st),
        .cnt    (cnt),
        .hidx   (hidx),
        .sb_idx (sb_idx),
        .hdr    (hdr_q),
        .run_q  (run_q),
        .lvl_q  (lvl_q),
        .mode   (mode),
        .data   (bus_data),
        .strobe (bus_strobe)
    );

    assign bus_mode = mode;

endmodule

// File: rtl/mbseq_checker.sv
module mbseq_checker (
    input logic       clk,
    input logic       rst,
    input logic [3:0] bus_mode,
    input logic [7:0] bus_data,
    input logic       bus_strobe,
    input logic       coef_ready
);

    assert_legal_code_R1: assert property (@(posedge clk) disable iff (rst)
        (bus_mode <= 4'd9) || (bus_mode == 4'd15));

    assert_no_strobe_in_wait_R2: assert property (@(posedge clk) disable iff (rst)
        (bus_mode == 4'd15) |-> !bus_strobe);

    assert_strobe_low_on_change_R2: assert property (@(posedge clk) disable iff (rst)
        !$stable(bus_mode) |-> !bus_strobe);

    assert_rise_after_settle_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(bus_strobe) |-> ($stable(bus_mode) && $stable(bus_data)));

    assert_data_held_R5: assert property (@(posedge clk) disable iff (rst)
        (bus_strobe && $past(bus_strobe)) |-> $stable(bus_data));

    assert_wait_data_zero_R6: assert property (@(posedge clk) disable iff (rst)
        (bus_mode == 4'd15) |-> (bus_data == 8'd0));

    assert_ready_placement_R8: assert property (@(posedge clk) disable iff (rst)
        coef_ready |-> ((bus_mode == 4'd15) || (bus_mode == 4'd7)));

endmodule

bind mb_out_seq mbseq_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .bus_mode   (bus_mode),
    .bus_data   (bus_data),
    .bus_strobe (bus_strobe),
    .coef_ready (coef_ready)
);

// File: tb/tb_mb_out_seq.sv
module tb_mb_out_seq;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic       rst, start;
    logic       hdr_dummy, hdr_fixed, hdr_inter, hdr_filtered, hdr_mcomp, hdr_fast_upd, hdr_skip;
    logic [7:0] hdr_group, hdr_mbnum, hdr_quant, hdr_mv_x, hdr_mv_y;
    logic [5:0] hdr_cbp;
    logic       coef_valid, coef_last, coef_ready, bus_strobe;
    logic [7:0] coef_run, coef_level, bus_data;
    logic [3:0] bus_mode;

    mb_out_seq dut (
        .clk(clk), .rst(rst), .start(start),
        .hdr_dummy(hdr_dummy), .hdr_fixed(hdr_fixed), .hdr_inter(hdr_inter),
        .hdr_filtered(hdr_filtered), .hdr_mcomp(hdr_mcomp), .hdr_fast_upd(hdr_fast_upd),
        .hdr_skip(hdr_skip), .hdr_group(hdr_group), .hdr_mbnum(hdr_mbnum),
        .hdr_cbp(hdr_cbp), .hdr_quant(hdr_quant), .hdr_mv_x(hdr_mv_x), .hdr_mv_y(hdr_mv_y),
        .coef_valid(coef_valid), .coef_run(coef_run), .coef_level(coef_level),
        .coef_last(coef_last), .coef_ready(coef_ready),
        .bus_data(bus_data), .bus_mode(bus_mode), .bus_strobe(bus_strobe)
    );

    // ctl = {skip, fast, mcomp, filtered, inter, fixed}
    typedef struct packed {
        logic       dummy;
        logic [5:0] ctl;
        logic [7:0] grp, mbn;
        logic [5:0] cbp;
        logic [7:0] qnt, mvx, mvy;
        logic [6:0] base;
        logic       stall;
        logic [11:0] restart;
    } vec_t;

    localparam int NVEC = 6;
    localparam vec_t VECS [NVEC] = '{
        '{1'b1, 6'b000001, 8'h11, 8'h22, 6'h3F,      8'h05, 8'h00, 8'h00, 7'd1,  1'b0, 12'd0},
        '{1'b0, 6'b001110, 8'h03, 8'h21, 6'h00,      8'h1F, 8'hFE, 8'h07, 7'd1,  1'b0, 12'd0},
        '{1'b0, 6'b110000, 8'h0C, 8'h01, 6'b100101,  8'h0A, 8'h03, 8'hF9, 7'd3,  1'b0, 12'd0},
        '{1'b0, 6'b000010, 8'h01, 8'h21, 6'b111111,  8'h01, 8'h80, 8'h7F, 7'd1,  1'b0, 12'd30},
        '{1'b0, 6'b001010, 8'h05, 8'h0B, 6'b000010,  8'h10, 8'h01, 8'hFF, 7'd64, 1'b0, 12'd100},
        '{1'b0, 6'b000110, 8'h02, 8'h03, 6'b000011,  8'h08, 8'h00, 8'h00, 7'd2,  1'b1, 12'd0}
    };
    localparam int STALL_REL = 48 + 400;

    logic [3:0] em [0:4095];
    logic [7:0] ed [0:4095];
    logic       es [0:4095];
    string      et [0:4095];
    int         elen;
    logic [7:0] cr [0:383];
    logic [7:0] cl [0:383];
    logic       clast [0:383];
    int         ctot;

    int checks = 0, errors = 0, cyc = 0;
    logic bad_code_seen = 1'b0;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (!rst && bus_mode >= 4'd10 && bus_mode <= 4'd14) bad_code_seen <= 1'b1;
        if (cyc > 150000) begin
            errors++;
            $display("FAIL watchdog: run did not finish, got cycle %0d expected below 150000", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic push(input logic [3:0] m, input logic [7:0] d, input int len, input string tag);
        for (int i = 0; i < len; i++) begin
            em[elen] = m; ed[elen] = d; es[elen] = (m != 4'hF) && (i != 0); et[elen] = tag;
            elen++;
        end
    endtask

    task automatic build(input vec_t v);
        logic [7:0] cb;
        logic first;
        int n, el;
        elen = 0; ctot = 0; first = 1'b1;
        // R3 control byte assembled from the flag list
        cb = {1'b0, v.ctl[5], v.ctl[4], 1'b0, v.ctl[3], v.ctl[2], v.ctl[1], v.ctl[0]};
        push(4'hF, 8'h00, 2, "R4");
        push(4'd2, cb, 2, "R3");
        if (!v.dummy) begin
            push(4'd0, v.grp, 2, "R5");
            push(4'd1, v.mbn, 2, "R5");
            push(4'd6, {2'b00, v.cbp}, 2, "R5");
            push(4'd3, v.qnt, 2, "R5");
            push(4'd4, v.mvx, 2, "R5");
            push(4'd5, v.mvy, 2, "R5");
            if (v.cbp != 6'd0) begin
                push(4'hF, 8'h00, 32, "R7");
                for (int b = 0; b < 6; b++) begin
                    if (v.cbp[b]) begin
                        n = int'(v.base) + b;
                        if (n > 64) n = 64;
                        push(4'd7, 8'(b), 15, "R7");
                        el = 15;
                        if (v.stall && first) begin
                            push(4'hF, 8'h00, 386, "R10");
                            el += 386;
                        end
                        first = 1'b0;
                        for (int k = 0; k < n; k++) begin
                            cr[ctot] = 8'((k * 3 + b) & 63);
                            cl[ctot] = 8'((k + 16 * b + 1) & 255);
                            clast[ctot] = (k == n - 1);
                            push(4'd8, cr[ctot], 2, "R8");
                            push(4'd9, cl[ctot], 2, "R8");
                            push(4'hF, 8'h00, 1, "R8");
                            ctot++;
                            el += 5;
                        end
                        if (el < 335) push(4'hF, 8'h00, 335 - el, "R9");
                    end
                end
            end
        end
    endtask

    task automatic set_hdr(input vec_t v, input logic scramble);
        hdr_dummy    = v.dummy ^ scramble;
        {hdr_skip, hdr_fast_upd, hdr_mcomp, hdr_filtered, hdr_inter, hdr_fixed} = v.ctl ^ {6{scramble}};
        hdr_group = v.grp ^ {8{scramble}};
        hdr_mbnum = v.mbn ^ {8{scramble}};
        hdr_cbp   = v.cbp ^ {6{scramble}};
        hdr_quant = v.qnt ^ {8{scramble}};
        hdr_mv_x  = v.mvx ^ {8{scramble}};
        hdr_mv_y  = v.mvy ^ {8{scramble}};
    endtask

    task automatic drive_coef(input int idx, input logic hold);
        coef_valid = !hold && (idx < ctot);
        coef_run   = (idx < ctot) ? cr[idx] : 8'h00;
        coef_level = (idx < ctot) ? cl[idx] : 8'h00;
        coef_last  = (idx < ctot) ? clast[idx] : 1'b0;
    endtask

    task automatic run_mb(input int vi);
        vec_t v;
        int idx;
        logic xfer, hold;
        string tag;
        v = VECS[vi];
        build(v);
        @(negedge clk);
        set_hdr(v, 1'b0);
        start = 1'b1; idx = 0; xfer = 1'b0; hold = v.stall;
        drive_coef(idx, hold);
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        set_hdr(v, 1'b1);   // R4: header must already be captured
        for (int c = 0; c < elen + 4; c++) begin
            logic [3:0] xm; logic [7:0] xd; logic xs;
            if (c < elen) begin xm = em[c]; xd = ed[c]; xs = es[c]; tag = et[c]; end
            else begin xm = 4'hF; xd = 8'h00; xs = 1'b0; tag = "R6"; end
            if (xm == bus_mode && xd == bus_data && xs != bus_strobe) tag = "R2";
            checks++;
            if (bus_mode !== xm || bus_data !== xd || bus_strobe !== xs) begin
                errors++;
                $display("FAIL %s vec %0d cycle %0d: mode/data/strobe got %0d/%h/%b expected %0d/%h/%b",
                         tag, vi, c, bus_mode, bus_data, bus_strobe, xm, xd, xs);
            end
            if (xfer) idx++;
            if (v.stall && c == STALL_REL) hold = 1'b0;
            start = (v.restart != 0) && (c == int'(v.restart));   // R11
            drive_coef(idx, hold);
            xfer = coef_ready && coef_valid;
            @(negedge clk);
        end
        checks++;   // R8: every offered coefficient consumed exactly once
        if (idx != ctot) begin
            errors++;
            $display("FAIL R8 vec %0d: coefficients taken got %0d expected %0d", vi, idx, ctot);
        end
    endtask

    initial begin
        rst = 1'b1; start = 1'b0;
        set_hdr(VECS[0], 1'b0);
        coef_valid = 1'b0; coef_run = '0; coef_level = '0; coef_last = 1'b0;
        ctot = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R12: reset state, held while no start arrives
        for (int i = 0; i < 4; i++) begin
            checks++;
            if (bus_mode !== 4'hF || bus_data !== 8'h00 || bus_strobe !== 1'b0 || coef_ready !== 1'b0) begin
                errors++;
                $display("FAIL R12 idle %0d: mode/data/strobe/ready got %0d/%h/%b/%b expected 15/00/0/0",
                         i, bus_mode, bus_data, bus_strobe, coef_ready);
            end
            @(negedge clk);
        end

        for (int vi = 0; vi < NVEC; vi++) run_mb(vi);

        // R12: reset in the middle of a macroblock
        build(VECS[2]);
        set_hdr(VECS[2], 1'b0);
        start = 1'b1;
        drive_coef(0, 1'b0);
        @(negedge clk);
        start = 1'b0;
        repeat (60) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        checks++;
        if (bus_mode !== 4'hF || bus_data !== 8'h00 || bus_strobe !== 1'b0 || coef_ready !== 1'b0) begin
            errors++;
            $display("FAIL R12 mid-run reset: mode/data/strobe/ready got %0d/%h/%b/%b expected 15/00/0/0",
                     bus_mode, bus_data, bus_strobe, coef_ready);
        end
        coef_valid = 1'b0;
        repeat (3) @(negedge clk);
        checks++;
        if (bus_mode !== 4'hF || bus_strobe !== 1'b0) begin
            errors++;
            $display("FAIL R12 after reset: mode/strobe got %0d/%b expected 15/0", bus_mode, bus_strobe);
        end

        // R1: no unused code appeared at any sampled edge
        checks++;
        if (bad_code_seen) begin
            errors++;
            $display("FAIL R1: unused mode code seen got 1 expected 0");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule